// File: doc/BRIEF.md
# Transmit Queue with Qualified Flush Sequencer

This block is the transmit-side cell queue of one port on a shared multi-port bus. A small synchronous FIFO stores outgoing bytes. A master on the bus selects the port by placing an address on a 3-bit bus that matches the port's strapped 3-bit identity. While the port is selected, the master can push data with an active-low write enable and can watch the queue's status flags. An internal consumer drains the queue through a simple read port.

The master can flush the queue without touching the global reset. It holds an active-low flush request on the addressed port for a run of clock edges. The run counter only advances while the write enable is idle. The request, the address match and the idle enable must all hold for the whole run. A break in any of them cancels the run, and the next attempt counts again from zero. When the run is complete, the flags are forced to a Full view and every write is refused. That state lasts until the master releases the request or stops addressing the port. The queue then reports Empty, which tells the master the flush is done. After a flush, the port does not accept writes again until the write enable has been seen idle for one clock.

Top module: `txq_reset_ctrl`

## Requirements
- R1: When `bus_addr` equals `port_addr`, a write is accepted on each rising edge where `wr_en_n` is 0, the port is not in the forced state, no post-flush lockout is pending and fewer than DEPTH entries are stored. Accepted bytes leave on `rd_data` in first-in first-out order while `rd_en` is 1 and `rd_valid` is 1.
- R2: A flush happens on the RUN_LEN-th (default 8) consecutive rising edge at which the address matches, `flush_req_n` is 0 and `wr_en_n` is 1. After RUN_LEN-1 such edges the flags still show the normal state.
- R3: If the address match is lost or `flush_req_n` returns to 1 before the run completes, nothing is flushed, and a later run needs a full RUN_LEN edges again.
- R4: Any edge where `wr_en_n` is 0 resets the run counter, so a request held while the port is selected for writing never flushes the queue. With the match and the enable held permanently active, no flush ever occurs.
- R5: `flags_oe` is 1 exactly while `bus_addr` equals `port_addr`, including during a flush run.
- R6: From the edge that completes the run, the forced state shows Full: `full_n`=0, `cell_avail`=0, `empty_n`=1.
- R7: In the forced state no write is accepted and `rd_valid` is 0. Entries stored before the flush are discarded.
- R8: The forced state lasts while the address matches and `flush_req_n` is 0. If the match is removed, `flags_oe` goes to 0 and the forced state ends.
- R9: On the first edge where the forced state ends, the flags show Empty: `empty_n`=0, `full_n`=1, `cell_avail`=1.
- R10: After a flush, writes are refused until the port samples `wr_en_n`=1 on an edge outside the forced state.
- R11: In normal operation `full_n` is 0 and `cell_avail` is 0 once DEPTH-SLACK (default 12) entries are stored. SLACK (default 4) further writes are still accepted, and a write at DEPTH entries is refused.
- R12: After `rst_n` is 0, the queue is empty: `empty_n`=0, `full_n`=1, `cell_avail`=1, `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr | input | 3 | Port address presented on the shared bus |
| port_addr | input | 3 | Strapped identity of this port |
| flush_req_n | input | 1 | Active-low queue flush request |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | 8 | Byte to enqueue |
| rd_en | input | 1 | Consumer read request |
| rd_data | output | 8 | Head-of-queue byte |
| rd_valid | output | 1 | Head byte is valid and may be read |
| full_n | output | 1 | Active-low Full flag value |
| empty_n | output | 1 | Active-low Empty flag value |
| cell_avail | output | 1 | Room for another cell |
| flags_oe | output | 1 | Flag outputs would be driven |

## Verification
If the run counter advances early or fails to clear, `full_n` falls one or more edges before or after the RUN_LEN-th qualifying edge. That difference shows up within a single run. If the forced state or the lockout is stuck, stray bytes reach the read port, or bytes are missing there. The scoreboard reports this on the very next drain. A level count that is not cleared by the flush shows up as stale bytes at `rd_data` right after completion, or as Empty never appearing one edge after release.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // address comparison used for port selection
  function automatic logic addr_hit(input logic [2:0] a, input logic [2:0] b);
    return a == b;
  endfunction

  // wrap-around pointer step for a queue of the given depth
  function automatic int unsigned ptr_step(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // level at which the Full flag rises, leaving slack for late writes
  function automatic int unsigned full_mark(input int unsigned depth, input int unsigned slack);
    return depth - slack;
  endfunction
endpackage

// File: rtl/txq_flush_seq.sv
module txq_flush_seq #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_hit,
  input  logic flush_req_n,
  input  logic wr_en_n,
  output logic forced,
  output logic lockout,
  output logic flush_fire,
  output logic [$clog2(RUN_LEN)-1:0] run_cnt
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

  logic hold;
  logic qualify;

  assign hold       = addr_hit && !flush_req_n;
  assign qualify    = hold && wr_en_n;
  assign flush_fire = !forced && qualify && (run_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      forced  <= 1'b0;
      lockout <= 1'b0;
    end else begin
      if (forced) begin
        run_cnt <= '0;
        if (!hold) forced <= 1'b0;
      end else if (flush_fire) begin
        run_cnt <= '0;
        forced  <= 1'b1;
      end else if (qualify) begin
        run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
      end

      if (flush_fire)             lockout <= 1'b1;
      else if (!forced && wr_en_n) lockout <= 1'b0;
    end
  end
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ok,
  input  logic rd_ok,
  input  logic flush,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  import txq_pkg::*;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= PTR_W'(ptr_step(int'(wr_ptr), DEPTH));
      if (rd_ok) rd_ptr <= PTR_W'(ptr_step(int'(rd_ptr), DEPTH));
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int DEPTH = 16,
  parameter int SLACK = 4
) (
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic forced,
  input  logic addr_hit,
  output logic full_n,
  output logic empty_n,
  output logic cell_avail,
  output logic flags_oe
);
  import txq_pkg::*;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] MARK = LVL_W'(full_mark(DEPTH, SLACK));

  logic full_state;

  assign full_state = forced || (level >= MARK);
  assign full_n     = !full_state;
  assign cell_avail = !full_state;
  assign empty_n    = forced || (level != '0);
  assign flags_oe   = addr_hit;
endmodule

// File: rtl/txq_reset_ctrl.sv
module txq_reset_ctrl #(
  parameter int WIDTH   = 8,
  parameter int DEPTH   = 16,
  parameter int SLACK   = 4,
  parameter int RUN_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic [2:0]       port_addr,
  input  logic             flush_req_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full_n,
  output logic             empty_n,
  output logic             cell_avail,
  output logic             flags_oe
);
  import txq_pkg::*;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int RUN_W = $clog2(RUN_LEN);

  logic             addr_match;
  logic             forced;
  logic             lockout;
  logic             flush_fire;
  logic [RUN_W-1:0] run_cnt;
  logic [LVL_W-1:0] level;
  logic             wr_accept;
  logic             rd_accept;

  assign addr_match = addr_hit(bus_addr, port_addr);
  assign wr_accept  = addr_match && !wr_en_n && !forced && !lockout
                      && (level < LVL_W'(DEPTH));
  assign rd_valid   = (level != '0) && !forced;
  assign rd_accept  = rd_en && rd_valid;

  txq_flush_seq #(.RUN_LEN(RUN_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr_hit(addr_match),
    .flush_req_n(flush_req_n), .wr_en_n(wr_en_n),
    .forced(forced), .lockout(lockout), .flush_fire(flush_fire),
    .run_cnt(run_cnt)
  );

  txq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_accept), .rd_ok(rd_accept),
    .flush(flush_fire), .wr_data(wr_data), .rd_data(rd_data), .level(level)
  );

  txq_flags #(.DEPTH(DEPTH), .SLACK(SLACK)) u_flags (
    .level(level), .forced(forced), .addr_hit(addr_match),
    .full_n(full_n), .empty_n(empty_n), .cell_avail(cell_avail),
    .flags_oe(flags_oe)
  );
endmodule

// File: rtl/txq_reset_ctrl_chk.sv
module txq_reset_ctrl_chk #(
  parameter int DEPTH   = 16,
  parameter int RUN_LEN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic [2:0] bus_addr,
  input logic [2:0] port_addr,
  input logic flush_req_n,
  input logic wr_en_n,
  input logic full_n,
  input logic empty_n,
  input logic cell_avail,
  input logic flags_oe,
  input logic addr_match,
  input logic forced,
  input logic lockout,
  input logic flush_fire,
  input logic wr_accept,
  input logic [$clog2(RUN_LEN)-1:0] run_cnt,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int LVL_W = $clog2(DEPTH + 1);

  assert_fire_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(forced) |-> ($past(run_cnt) == RUN_W'(RUN_LEN - 1)));

  assert_abort_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced && (bus_addr != port_addr || flush_req_n)) |=> (run_cnt == '0));

  assert_enable_inhibits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced && !wr_en_n) |=> (run_cnt == '0));

  assert_flags_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != port_addr) |-> !flags_oe);

  assert_forced_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    forced |-> (!full_n && !cell_avail && empty_n));

  assert_forced_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    forced |-> !wr_accept);

  assert_flush_discards_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |=> (level == '0));

  assert_release_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(forced) |-> (!empty_n && full_n && cell_avail));

  assert_lockout_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> !wr_accept);

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
endmodule

bind txq_reset_ctrl txq_reset_ctrl_chk #(.DEPTH(DEPTH), .RUN_LEN(RUN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .port_addr(port_addr),
  .flush_req_n(flush_req_n), .wr_en_n(wr_en_n), .full_n(full_n),
  .empty_n(empty_n), .cell_avail(cell_avail), .flags_oe(flags_oe),
  .addr_match(addr_match), .forced(forced), .lockout(lockout),
  .flush_fire(flush_fire), .wr_accept(wr_accept), .run_cnt(run_cnt),
  .level(level)
);

// File: tb/txq_reset_ctrl_bench.sv
module txq_reset_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int SLACK = 4;
  localparam int RUN   = 8;
  localparam logic [2:0] ME = 3'd5;

  logic clk = 1'b0;
  logic rst_n, flush_req_n, wr_en_n, rd_en;
  logic [2:0] bus_addr;
  logic [7:0] wr_data, rd_data;
  logic rd_valid, full_n, empty_n, cell_avail, flags_oe;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  txq_reset_ctrl u_txq_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .port_addr(ME),
    .flush_req_n(flush_req_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .full_n(full_n),
    .empty_n(empty_n), .cell_avail(cell_avail), .flags_oe(flags_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d, input bit accept);
    wr_en_n = 1'b0;
    wr_data = d;
    @(negedge clk);
    if (accept) exp_q.push_back(d);
  endtask

  task automatic drain();
    rd_en = 1'b1;
    for (int g = 0; g < 64 && exp_q.size() > 0; g++) @(negedge clk);
    rd_en = 1'b0;
    #1;
    chk(rd_valid == 1'b0, "R1", "no stray data after drain", rd_valid, 0);
  endtask

  task automatic flag_chk(input string req, input int f, input int e, input int c);
    chk(full_n == f, req, "full_n", full_n, f);
    chk(empty_n == e, req, "empty_n", empty_n, e);
    chk(cell_avail == c, req, "cell_avail", cell_avail, c);
  endtask

  // scoreboard monitor: samples just before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/2 - 1);
      if (rd_en && rd_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected read data", rd_data, -1);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(rd_data == e, "R1", "read data order", rd_data, e);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 3'd0; flush_req_n = 1'b1; wr_en_n = 1'b1;
    wr_data = '0; rd_en = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R12 reset state, R5 no drive when unaddressed
    flag_chk("R12", 1, 0, 1);
    chk(rd_valid == 1'b0, "R12", "rd_valid", rd_valid, 0);
    chk(flags_oe == 1'b0, "R5", "flags_oe unaddressed", flags_oe, 0);
    bus_addr = ME; #1;
    chk(flags_oe == 1'b1, "R5", "flags_oe addressed", flags_oe, 1);

    // R1 basic ordering
    put(8'hA1, 1); put(8'hB2, 1); put(8'hC3, 1);
    wr_en_n = 1'b1;
    drain();
    chk(empty_n == 1'b0, "R1", "empty after drain", empty_n, 0);

    // R11 slack after Full
    for (int i = 0; i < DEPTH - SLACK; i++) put(8'(8'h10 + i), 1);
    wr_en_n = 1'b1; #1;
    flag_chk("R11", 0, 1, 0);
    for (int i = 0; i < SLACK; i++) put(8'(8'h40 + i), 1);
    put(8'hEE, 0);
    wr_en_n = 1'b1;
    drain();

    // R2/R6/R7/R9/R10 full flush run, released with enable held active
    for (int i = 0; i < 5; i++) put(8'(8'h60 + i), 1);
    wr_en_n = 1'b1;
    flush_req_n = 1'b0;
    step(RUN - 1);
    chk(full_n == 1'b1, "R2", "no flush before run end", full_n, 1);
    step(1);
    flag_chk("R6", 0, 1, 0);
    chk(rd_valid == 1'b0, "R7", "rd_valid forced", rd_valid, 0);
    exp_q.delete();
    put(8'h77, 0); put(8'h78, 0);
    chk(full_n == 1'b0, "R8", "forced holds", full_n, 0);
    flush_req_n = 1'b1;
    step(1);
    flag_chk("R9", 1, 0, 1);
    chk(flags_oe == 1'b1, "R8", "flags still driven", flags_oe, 1);
    put(8'h79, 0);
    chk(rd_valid == 1'b0, "R10", "write refused in lockout", rd_valid, 0);
    wr_en_n = 1'b1;
    step(1);
    put(8'h42, 1);
    wr_en_n = 1'b1;
    drain();

    // R3 abort by request release, then full restart
    flush_req_n = 1'b0; step(5);
    flush_req_n = 1'b1; step(1);
    flush_req_n = 1'b0; step(RUN - 1);
    chk(full_n == 1'b1, "R3", "restart after request drop", full_n, 1);
    step(1);
    chk(full_n == 1'b0, "R3", "flush after full restart", full_n, 0);
    flush_req_n = 1'b1; step(2);

    // R3 abort by match loss; R8 release by match removal
    flush_req_n = 1'b0; step(6);
    bus_addr = 3'd1; step(1);
    bus_addr = ME; step(RUN - 1);
    chk(full_n == 1'b1, "R3", "restart after match drop", full_n, 1);
    step(1);
    chk(full_n == 1'b0, "R3", "flush after match restart", full_n, 0);
    bus_addr = 3'd1; step(1);
    chk(flags_oe == 1'b0, "R8", "flags off on match removal", flags_oe, 0);
    flush_req_n = 1'b1; bus_addr = ME; #1;
    flag_chk("R8", 1, 0, 1);
    step(1);

    // R4 enable active holds off the flush entirely
    flush_req_n = 1'b0;
    for (int i = 0; i < 10; i++) put(8'(8'h80 + i), 1);
    wr_en_n = 1'b1; flush_req_n = 1'b1; #1;
    chk(empty_n == 1'b1, "R4", "data kept, no flush", empty_n, 1);
    chk(full_n == 1'b1, "R4", "not forced full", full_n, 1);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule